// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer Unit

The block holds four independent down-counters behind a plain 32-bit register bus with address, write strobe, write data and combinational read data. Each counter has a load register that sets the count at once and a background-load register that is used only when the counter next passes zero. The elapsed time since a load is the bitwise complement of the current value. Every channel has its own prescaler that divides the clock by 1, 16 or 256. The counter is 16 or 32 bits wide, and it runs in one of three modes: it stops after one pass, it reloads from the background value, or it wraps to all ones. When a counter passes zero it raises a per-channel raw interrupt bit. A mask register selects which raw bits drive the single interrupt output, and software clears raw bits by writing ones.

Each channel is a two-state machine. HALT holds the count and keeps the prescaler at zero. RUN decrements once per prescaler tick. The transitions are:
- START: a control write with bit 7 set takes HALT to RUN.
- STOP: a control write with bit 7 clear takes RUN to HALT.
- EXPIRE: an underflow in one-shot mode takes RUN to HALT.

All other cycles stay in the current state. A control write in the same cycle as an underflow takes precedence over EXPIRE. Writes take effect at the clock edge that samples the write strobe. The top level decodes the bus and holds the shared interrupt registers.

Top module: `quad_down_timer`

## Requirements
- R1: After reset every register reads zero, all channels are in HALT and `irq_o` is low. Shared registers sit at mask 0x00, raw status 0x04, masked status 0x08 and clear 0x0C. Channel n (0..3) uses base 0x10+0x10*n, with load at +0x0, current value at +0x4, control at +0x8 and background load at +0xC.
- R2: A write to a channel's load register sets its counter at that clock edge and also copies the value into its background-load register.
- R3: In RUN the counter decrements once per prescaler tick. Control bits 3:2 select the divider: 00 ticks every cycle, 01 every 16 cycles and 10 every 256 cycles, counted from the edge that starts or loads the channel. The value 11 also divides by 256.
- R4: With control bit 1 clear, only the low 16 bits count and are read back, and the upper 16 bits read as zero. With bit 1 set, all 32 bits count.
- R5: One-shot mode (control bit 0 set, overriding bit 6): a tick at count zero sets the raw bit, clears the enable (control bit 7 reads 0) and leaves the counter at zero.
- R6: Periodic mode (bit 0 clear, bit 6 set): a tick at count zero reloads the background-load value. A write to the background-load register alone does not change the current count.
- R7: Free-running mode (bits 0 and 6 clear): a tick at count zero wraps the counter to all ones of the selected width.
- R8: Clearing the enable bit freezes the counter. Setting it again restarts the prescaler from zero, so the next decrement comes a full divider period later.
- R9: Raw bit n is set by channel n passing zero. Masked status equals raw AND mask, `irq_o` is the OR of the masked bits, and writing 1 to bit n of the clear register clears raw bit n.
- R10: The control register reads back bits 7, 6, 3:2, 1 and 0 as written, and bits 5:4 and 31:8 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for bus and counters |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address of the register accessed |
| bus_we | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
A write is sampled at edge E, and reads of registers it sets show the new value right after E. With divide-by-1, a running counter shows its load value minus k after edge E+k. With a divider D, the first decrement appears after edge E+D and the value after E+D-1 is unchanged. A tick at count zero at edge T updates the raw bit, the counter and the enable at T, so `irq_o` and masked status follow in the same cycle. The bench drives on falling edges and reads a few nanoseconds after a falling edge. It counts whole falling edges from the write and checks one cycle before and at each due edge.

// File: rtl/qtmr_pkg.sv
package qtmr_pkg;

    localparam int DATA_W = 32;

    // control field positions (decoded by the channel)
    localparam int CTL_EN     = 7;
    localparam int CTL_PER    = 6;
    localparam int CTL_PRE_HI = 3;
    localparam int CTL_PRE_LO = 2;
    localparam int CTL_WIDE   = 1;
    localparam int CTL_ONE    = 0;

    // word index inside a 16-byte block
    localparam logic [1:0] CH_LOAD = 2'd0;
    localparam logic [1:0] CH_VAL  = 2'd1;
    localparam logic [1:0] CH_CTRL = 2'd2;
    localparam logic [1:0] CH_BGL  = 2'd3;

    localparam logic [1:0] SH_MASK = 2'd0;
    localparam logic [1:0] SH_RAW  = 2'd1;
    localparam logic [1:0] SH_MIS  = 2'd2;
    localparam logic [1:0] SH_CLR  = 2'd3;

    typedef enum logic {
        CH_HALT = 1'b0,
        CH_RUN  = 1'b1
    } chan_state_e;

    typedef enum logic [1:0] {
        MODE_FREE     = 2'd0,
        MODE_PERIODIC = 2'd1,
        MODE_ONESHOT  = 2'd2
    } cnt_mode_e;

endpackage

// File: rtl/qtmr_prescale.sv
module qtmr_prescale #(
    parameter int MID_LOG2 = 4,
    parameter int HI_LOG2  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       restart,
    input  logic [1:0] sel,
    output logic       tick
);
    localparam int PW = HI_LOG2;
    localparam logic [PW-1:0] LIM_MID = {PW{1'b1}} >> (PW - MID_LOG2);
    localparam logic [PW-1:0] LIM_HI  = {PW{1'b1}};

    logic [PW-1:0] div_q;
    logic [PW-1:0] limit;

    always_comb begin
        unique case (sel)
            2'b00:   limit = '0;
            2'b01:   limit = LIM_MID;
            default: limit = LIM_HI;
        endcase
    end

    assign tick = run && !restart && (div_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (!run || restart || tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

endmodule

// File: rtl/qtmr_chan.sv
module qtmr_chan
    import qtmr_pkg::*;
#(
    parameter int NARROW_W = 16,
    parameter int MID_LOG2 = 4,
    parameter int HI_LOG2  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_load,
    input  logic              wr_bgl,
    input  logic              wr_ctrl,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] value_o,
    output logic [DATA_W-1:0] bgl_o,
    output logic [DATA_W-1:0] ctrl_o,
    output logic              expire_o,
    output logic              running_o,
    output logic              oneshot_o
);
    localparam logic [DATA_W-1:0] NARROW_MASK =
        {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    chan_state_e       state_q, state_d;
    cnt_mode_e         mode;
    logic [DATA_W-1:0] cnt_q, bgl_q;
    logic              per_q, wide_q, one_q;
    logic [1:0]        pre_q;
    logic [DATA_W-1:0] width_mask, cnt_view;
    logic              tick, underflow;

    qtmr_prescale #(
        .MID_LOG2(MID_LOG2),
        .HI_LOG2 (HI_LOG2)
    ) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state_q == CH_RUN),
        .restart(wr_load),
        .sel    (pre_q),
        .tick   (tick)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_HALT;
        else        state_q <= state_d;
    end

    // next state: START, STOP, EXPIRE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_HALT: begin
                if (wr_ctrl && wdata[CTL_EN]) state_d = CH_RUN;
            end
            CH_RUN: begin
                if (wr_ctrl)
                    state_d = wdata[CTL_EN] ? CH_RUN : CH_HALT;
                else if (underflow && mode == MODE_ONESHOT)
                    state_d = CH_HALT;
            end
            default: state_d = CH_HALT;
        endcase
    end

    // outputs and derived values
    always_comb begin
        if (one_q)      mode = MODE_ONESHOT;
        else if (per_q) mode = MODE_PERIODIC;
        else            mode = MODE_FREE;
        width_mask = wide_q ? {DATA_W{1'b1}} : NARROW_MASK;
        cnt_view   = cnt_q & width_mask;
        underflow  = tick && (cnt_view == '0);
        value_o    = cnt_view;
        bgl_o      = bgl_q;
        ctrl_o     = '0;
        ctrl_o[CTL_EN]                  = (state_q == CH_RUN);
        ctrl_o[CTL_PER]                 = per_q;
        ctrl_o[CTL_PRE_HI:CTL_PRE_LO]   = pre_q;
        ctrl_o[CTL_WIDE]                = wide_q;
        ctrl_o[CTL_ONE]                 = one_q;
        expire_o   = underflow;
        running_o  = (state_q == CH_RUN);
        oneshot_o  = (mode == MODE_ONESHOT);
    end

    // counter datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_load) begin
            cnt_q <= wdata;
        end else if (underflow) begin
            unique case (mode)
                MODE_ONESHOT:  cnt_q <= '0;
                MODE_PERIODIC: cnt_q <= bgl_q;
                default:       cnt_q <= width_mask;
            endcase
        end else if (tick) begin
            cnt_q <= (cnt_view - 1'b1) & width_mask;
        end
    end

    // background load and control fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bgl_q  <= '0;
            per_q  <= 1'b0;
            pre_q  <= 2'b00;
            wide_q <= 1'b0;
            one_q  <= 1'b0;
        end else begin
            if (wr_load || wr_bgl) bgl_q <= wdata;
            if (wr_ctrl) begin
                per_q  <= wdata[CTL_PER];
                pre_q  <= wdata[CTL_PRE_HI:CTL_PRE_LO];
                wide_q <= wdata[CTL_WIDE];
                one_q  <= wdata[CTL_ONE];
            end
        end
    end

endmodule

// File: rtl/quad_down_timer.sv
module quad_down_timer
    import qtmr_pkg::*;
#(
    parameter int N_CH     = 4,
    parameter int ADDR_W   = 8,
    parameter int NARROW_W = 16,
    parameter int MID_LOG2 = 4,
    parameter int HI_LOG2  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_o
);
    localparam int SEL_W = ADDR_W - 4;

    logic [SEL_W-1:0] blk_sel;
    logic [1:0]       word_sel;

    logic [N_CH-1:0]             chan_expire, chan_run, chan_oneshot, chan_touch;
    logic [N_CH-1:0][DATA_W-1:0] chan_value, chan_bgl, chan_ctrl;
    logic [N_CH-1:0]             mask_q, raw_q, mis;
    logic                        sh_hit;

    assign blk_sel  = bus_addr[ADDR_W-1:4];
    assign word_sel = bus_addr[3:2];
    assign sh_hit   = (blk_sel == '0);

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        logic hit;
        assign hit           = (blk_sel == SEL_W'(c + 1));
        assign chan_touch[c] = hit && bus_we;

        qtmr_chan #(
            .NARROW_W(NARROW_W),
            .MID_LOG2(MID_LOG2),
            .HI_LOG2 (HI_LOG2)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_load  (chan_touch[c] && word_sel == CH_LOAD),
            .wr_bgl   (chan_touch[c] && word_sel == CH_BGL),
            .wr_ctrl  (chan_touch[c] && word_sel == CH_CTRL),
            .wdata    (bus_wdata),
            .value_o  (chan_value[c]),
            .bgl_o    (chan_bgl[c]),
            .ctrl_o   (chan_ctrl[c]),
            .expire_o (chan_expire[c]),
            .running_o(chan_run[c]),
            .oneshot_o(chan_oneshot[c])
        );
    end

    // shared interrupt registers; a new event wins over a clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            raw_q  <= '0;
        end else begin
            if (bus_we && sh_hit && word_sel == SH_MASK)
                mask_q <= bus_wdata[N_CH-1:0];
            if (bus_we && sh_hit && word_sel == SH_CLR)
                raw_q <= (raw_q & ~bus_wdata[N_CH-1:0]) | chan_expire;
            else
                raw_q <= raw_q | chan_expire;
        end
    end

    assign mis   = raw_q & mask_q;
    assign irq_o = |mis;

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (sh_hit) begin
            unique case (word_sel)
                SH_MASK: bus_rdata = 32'(mask_q);
                SH_RAW:  bus_rdata = 32'(raw_q);
                SH_MIS:  bus_rdata = 32'(mis);
                default: bus_rdata = '0;
            endcase
        end
        for (int c = 0; c < N_CH; c++) begin
            if (blk_sel == SEL_W'(c + 1)) begin
                unique case (word_sel)
                    CH_LOAD: bus_rdata = chan_bgl[c];
                    CH_VAL:  bus_rdata = chan_value[c];
                    CH_CTRL: bus_rdata = chan_ctrl[c];
                    default: bus_rdata = chan_bgl[c];
                endcase
            end
        end
    end

endmodule

// File: rtl/qtmr_checker.sv
module qtmr_checker #(
    parameter int N_CH = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [N_CH-1:0]        expire,
    input logic [N_CH-1:0]        running,
    input logic [N_CH-1:0]        oneshot,
    input logic [N_CH-1:0]        touch,
    input logic [N_CH-1:0][31:0]  value,
    input logic [N_CH-1:0]        raw,
    input logic [N_CH-1:0]        mask,
    input logic                   irq
);
    for (genvar c = 0; c < N_CH; c++) begin : g_chk
        // R5: one-shot expiry stops the channel
        a_r5_oneshot_stops: assert property (@(posedge clk) disable iff (!rst_n)
            expire[c] && oneshot[c] && !touch[c] |=> !running[c]);
        // R5: expiry happens only at count zero
        a_r5_expire_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
            expire[c] |-> value[c] == 32'd0);
        // R8: a halted, untouched channel keeps its count
        a_r8_halt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
            !running[c] && !touch[c] |=> $stable(value[c]));
        // R9: expiry sets the raw bit
        a_r9_raw_sets: assert property (@(posedge clk) disable iff (!rst_n)
            expire[c] |=> raw[c]);
    end

    // R9: no interrupt with everything masked or nothing pending
    a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);
    a_r9_no_raw_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (raw == '0) |-> !irq);

endmodule

bind quad_down_timer qtmr_checker #(.N_CH(N_CH)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .expire (chan_expire),
    .running(chan_run),
    .oneshot(chan_oneshot),
    .touch  (chan_touch),
    .value  (chan_value),
    .raw    (raw_q),
    .mask   (mask_q),
    .irq    (irq_o)
);

// File: tb/tb_quad_down_timer.sv
module tb_quad_down_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_checks = 0;
    int n_errors = 0;

    quad_down_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
        .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] ca(input int ch, input int w);
        return 8'(16 + 16*ch + 4*w);
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; we = 1'b1; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic stop_all();
        for (int c = 0; c < 4; c++) wr(ca(c, 2), 32'h0);
        wr(8'h0C, 32'hF);
        wr(8'h00, 32'h0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(8'h00, v); chk("R1", "mask after reset", v, 0);
        rd(8'h04, v); chk("R1", "raw after reset", v, 0);
        rd(ca(0, 2), v); chk("R1", "ctrl0 after reset", v, 0);
        wait_n(1);
        rd(ca(3, 1), v); chk("R1", "val3 after reset", v, 0);
        chk("R1", "irq after reset", 32'(irq), 0);
    endtask

    task automatic t_load_count();
        logic [31:0] v;
        wr(ca(0, 0), 100);
        rd(ca(0, 1), v); chk("R2", "load sets count", v, 100);
        rd(ca(0, 3), v); chk("R2", "load copies to background", v, 100);
        wr(ca(0, 2), 32'h82);
        rd(ca(0, 1), v); chk("R3", "no tick at enable edge", v, 100);
        wait_n(5);
        rd(ca(0, 1), v); chk("R3", "div1 five ticks", v, 95);
    endtask

    task automatic t_prescale();
        logic [31:0] v;
        stop_all();
        wr(ca(1, 0), 10); wr(ca(1, 2), 32'h86);
        wait_n(15); rd(ca(1, 1), v); chk("R3", "div16 before tick", v, 10);
        wait_n(1);  rd(ca(1, 1), v); chk("R3", "div16 first tick", v, 9);
        wr(ca(2, 0), 3); wr(ca(2, 2), 32'h8E);
        wait_n(255); rd(ca(2, 1), v); chk("R3", "sel11 before tick", v, 3);
        wait_n(1);   rd(ca(2, 1), v); chk("R3", "sel11 first tick", v, 2);
        wr(ca(3, 0), 7); wr(ca(3, 2), 32'h8A);
        wait_n(255); rd(ca(3, 1), v); chk("R3", "div256 before tick", v, 7);
        wait_n(1);   rd(ca(3, 1), v); chk("R3", "div256 first tick", v, 6);
    endtask

    task automatic t_oneshot();
        logic [31:0] v;
        stop_all();
        wr(8'h00, 32'h2);
        wr(ca(1, 0), 3); wr(ca(1, 2), 32'h83);
        wait_n(3);
        rd(ca(1, 1), v); chk("R5", "reached zero", v, 0);
        rd(8'h04, v);    chk("R5", "no raw before underflow", v & 2, 0);
        chk("R9", "irq low before underflow", 32'(irq), 0);
        wait_n(1);
        rd(8'h04, v);    chk("R5", "raw set at underflow", v & 2, 2);
        rd(ca(1, 2), v); chk("R5", "enable cleared", v, 32'h03);
        rd(8'h08, v);    chk("R9", "masked status", v, 2);
        chk("R9", "irq high", 32'(irq), 1);
        wait_n(3);
        rd(ca(1, 1), v); chk("R5", "stays at zero", v, 0);
        wr(8'h0C, 32'h2);
        rd(8'h04, v);    chk("R9", "clear raw", v & 2, 0);
        chk("R9", "irq low after clear", 32'(irq), 0);
    endtask

    task automatic t_periodic();
        logic [31:0] v;
        stop_all();
        wr(ca(2, 0), 2); wr(ca(2, 3), 5);
        rd(ca(2, 1), v); chk("R6", "background write leaves count", v, 2);
        wr(ca(2, 2), 32'hC0);
        wait_n(3);
        rd(ca(2, 1), v); chk("R6", "reload from background", v, 5);
        rd(8'h04, v);    chk("R6", "raw on reload", v & 4, 4);
        wait_n(1);
        rd(ca(2, 1), v); chk("R6", "counts after reload", v, 4);
    endtask

    task automatic t_width_free();
        logic [31:0] v;
        stop_all();
        wr(ca(3, 0), 32'h12345);
        rd(ca(3, 1), v); chk("R4", "16-bit readback", v, 32'h2345);
        wr(ca(3, 0), 1); wr(ca(3, 2), 32'h80);
        wait_n(1);
        rd(ca(3, 1), v); chk("R4", "16-bit at zero", v, 0);
        wait_n(1);
        rd(ca(3, 1), v); chk("R7", "16-bit wrap", v, 32'hFFFF);
        rd(8'h04, v);    chk("R7", "raw on wrap", v & 8, 8);
        wr(ca(0, 0), 0); wr(ca(0, 2), 32'h82);
        wait_n(1);
        rd(ca(0, 1), v); chk("R7", "32-bit wrap", v, 32'hFFFF_FFFF);
    endtask

    task automatic t_disable();
        logic [31:0] v;
        stop_all();
        wr(ca(0, 0), 50); wr(ca(0, 2), 32'h86);
        wait_n(20);
        wr(ca(0, 2), 32'h06);
        rd(ca(0, 1), v); chk("R8", "frozen on disable", v, 49);
        wait_n(20);
        rd(ca(0, 1), v); chk("R8", "still frozen", v, 49);
        wr(ca(0, 2), 32'h86);
        wait_n(15);
        rd(ca(0, 1), v); chk("R8", "prescaler restarted", v, 49);
        wait_n(1);
        rd(ca(0, 1), v); chk("R8", "tick after full period", v, 48);
    endtask

    task automatic t_irq_mask();
        logic [31:0] v;
        stop_all();
        wr(ca(0, 0), 1); wr(ca(0, 2), 32'h83);
        wait_n(2);
        rd(8'h04, v); chk("R9", "raw without mask", v & 1, 1);
        rd(8'h08, v); chk("R9", "masked zero", v, 0);
        chk("R9", "irq masked off", 32'(irq), 0);
        wr(8'h00, 32'h1);
        rd(8'h08, v); chk("R9", "masked after unmask", v, 1);
        chk("R9", "irq after unmask", 32'(irq), 1);
        wr(8'h0C, 32'h1);
        rd(8'h04, v); chk("R9", "raw cleared", v, 0);
        chk("R9", "irq after clear", 32'(irq), 0);
    endtask

    task automatic t_ctrl_readback();
        logic [31:0] v;
        stop_all();
        wr(ca(2, 2), 32'h4F);
        rd(ca(2, 2), v); chk("R10", "ctrl fields", v, 32'h4F);
        wr(ca(2, 2), 32'hFFFF_FF7F);
        rd(ca(2, 2), v); chk("R10", "unused bits read zero", v, 32'h4F);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_load_count();
        t_prescale();
        t_oneshot();
        t_periodic();
        t_width_free();
        t_disable();
        t_irq_mask();
        t_ctrl_readback();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule